// File: doc/BRIEF.md
# DRAM Refresh and Low-Power Mode Manager

This block keeps a DDR memory refreshed and moves it in and out of its two low-power states. A down-counter, reloaded from a 16-bit interval input each time a refresh goes out, marks a refresh as due. The manager then asks the command engine for the bus with `ref_req`. Once `eng_grant` says all banks are precharged, it emits a one-cycle AUTO REFRESH strobe on `issue_ref`. After the strobe it holds `busy` for the programmed refresh recovery time.

User commands pass through the manager. Two command codes are toggles. POWER_DOWN drops the clock enable, and the same code raises it again. SELF_REFRESH issues a refresh strobe with the clock enable low, and the same code brings the memory back. A long busy window follows the exit from self-refresh. While either low-power state is active, every other command is dropped. Refresh keeps running during power-down: the manager wakes the memory, refreshes it, and puts it back to sleep without user action. During self-refresh the interval counter stands still, because the memory refreshes itself.

The engine forwards any data or configuration command it sees on `fwd_vld`/`fwd_cmd`. A pending refresh always wins over a new user command. The user must hold a command until `busy` is low.

Top module: `refresh_power_mgr`

## Requirements
- R1: After reset, `cke` is 1 and `busy`, `ref_req`, `issue_ref` and `fwd_vld` are 0.
- R2: Each refresh strobe reloads the interval counter with `refi_cfg`-1. With `eng_grant` held high in normal mode, consecutive refresh strobes are exactly `refi_cfg` clocks apart, and `ref_req` rises `refi_cfg`-1 clocks after a strobe.
- R3: A refresh strobe occurs only in the cycle after `eng_grant` was sampled high. While the grant is low, `ref_req` stays high and no strobe is issued.
- R4: `busy` is high in the strobe cycle and for `trfc_cfg`-1 further cycles, then falls. A `trfc_cfg` of 0 behaves as 1.
- R5: While a refresh is due in normal mode, `busy` is high and no user command is forwarded.
- R6: In normal mode, with `busy` low, any command code other than NOP (000), POWER_DOWN (101) and SELF_REFRESH (110) is forwarded in the same cycle on `fwd_cmd` with `fwd_vld` high. NOP is not forwarded.
- R7: A POWER_DOWN (101) accepted in normal mode drives `cke` low from the next cycle. In power-down, other commands are not forwarded. A second 101 raises `cke` in the next cycle.
- R8: In power-down, a due refresh raises `cke`. After `WAKE_CYC` cycles and a grant, the refresh strobe is issued with `cke` high. `cke` falls again exactly `trfc_cfg` cycles after the strobe, and no command is needed.
- R9: A SELF_REFRESH (110), whatever the address, raises `ref_req`. The grant then yields a refresh strobe with `cke` low in the same cycle, and `cke` stays low.
- R10: In self-refresh, other commands are dropped, no refresh is issued and the interval counter is frozen. A second 110 raises `cke` in the next cycle. The next refresh comes `refi_cfg` clocks after that rise.
- R11: After the self-refresh exit, `busy` stays high for `SRX_CYC` (default 200) cycles from the `cke` rise, then falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| user_cmd | input | 3 | User command code, 000 when idle |
| refi_cfg | input | REFI_W | Refresh interval in clocks |
| trfc_cfg | input | TRFC_W | Refresh recovery time in clocks |
| eng_grant | input | 1 | Engine reports all banks precharged and bus free |
| ref_req | output | 1 | Request for the bus to refresh or enter self-refresh |
| issue_ref | output | 1 | One-cycle AUTO REFRESH command strobe |
| cke | output | 1 | Memory clock enable |
| busy | output | 1 | No user command is accepted this cycle |
| fwd_vld | output | 1 | A user command is passed to the engine |
| fwd_cmd | output | 3 | Passed command code, 000 when none |

## Verification
The bench targets the timing edges of refresh scheduling. It measures strobe spacing against the interval, where an off-by-one reload shows up as a gap of one clock too many. It checks that a `trfc_cfg` of zero still gives one recovery cycle, which a design that wraps the count would turn into a 16-cycle stall. It holds the grant low to prove that no strobe leaks out before the engine agrees, and that a waiting refresh blocks a read. In the low-power states it checks that power-down refresh returns `cke` low with no user toggle. It also checks that the self-refresh exit waits the full busy window. Finally, a stay in self-refresh longer than the interval must not be counted: a design that keeps counting would refresh at once after the exit instead of one full interval later.

// File: rtl/rpm_pkg.sv
package rpm_pkg;

  typedef enum logic [2:0] {
    M_NORM  = 3'd0,
    M_PD    = 3'd1,
    M_PWAKE = 3'd2,
    M_TRFC  = 3'd3,
    M_SRQ   = 3'd4,
    M_SR    = 3'd5,
    M_SRX   = 3'd6
  } mode_e;

  localparam logic [2:0] UC_NOP = 3'b000;
  localparam logic [2:0] UC_PDN = 3'b101;
  localparam logic [2:0] UC_SRF = 3'b110;

  // clock enable is low only while the memory sleeps
  function automatic logic cke_for(input mode_e m);
    return !(m == M_PD || m == M_SR);
  endfunction

  // user-side busy: idle states only block when a refresh is due
  function automatic logic busy_for(input mode_e m, input logic due);
    case (m)
      M_NORM, M_PD: return due;
      M_SR:         return 1'b0;
      default:      return 1'b1;
    endcase
  endfunction

  // commands handed to the engine rather than consumed here
  function automatic logic cmd_passes(input logic [2:0] c);
    return !(c == UC_NOP || c == UC_PDN || c == UC_SRF);
  endfunction

endpackage

// File: rtl/rpm_refresh_timer.sv
module rpm_refresh_timer #(
  parameter int REFI_W   = 16,
  parameter int REFI_RST = 2228
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reload,
  input  logic              hold,
  input  logic [REFI_W-1:0] refi,
  output logic [REFI_W-1:0] cnt,
  output logic              due
);

  logic [REFI_W-1:0] reload_val;
  assign reload_val = (refi == '0) ? '0 : refi - REFI_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt <= REFI_W'(REFI_RST - 1);
    else if (reload)              cnt <= reload_val;
    else if (!hold && cnt != '0)  cnt <= cnt - REFI_W'(1);
  end

  assign due = (cnt == '0);

endmodule

// File: rtl/rpm_delay_timer.sv
module rpm_delay_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         done
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= val;
    else if (cnt != '0)      cnt <= cnt - W'(1);
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/rpm_mode_fsm.sv
module rpm_mode_fsm
  import rpm_pkg::*;
#(
  parameter int TRFC_W   = 4,
  parameter int DLY_W    = 8,
  parameter int WAKE_CYC = 1,
  parameter int SRX_CYC  = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        user_cmd,
  input  logic [TRFC_W-1:0] trfc_cfg,
  input  logic              eng_grant,
  input  logic              due,
  input  logic              dly_done,
  output mode_e             mode_q,
  output logic              dly_load,
  output logic [DLY_W-1:0]  dly_val,
  output logic              fire,
  output logic              timer_hold,
  output logic              issue_ref,
  output logic              ref_req,
  output logic              cke,
  output logic              busy,
  output logic              fwd_vld,
  output logic [2:0]        fwd_cmd
);

  mode_e st_n;
  logic  ret_pd_q, ret_pd_n;

  // recovery count: the strobe cycle is the first busy cycle, zero acts as one
  function automatic logic [DLY_W-1:0] trfc_load(input logic [TRFC_W-1:0] t);
    return (t == '0) ? '0 : DLY_W'(t) - DLY_W'(1);
  endfunction

  always_comb begin
    st_n     = mode_q;
    ret_pd_n = ret_pd_q;
    fire     = 1'b0;
    dly_load = 1'b0;
    dly_val  = '0;
    case (mode_q)
      M_NORM: begin
        if (due) begin
          if (eng_grant) begin
            fire     = 1'b1;
            st_n     = M_TRFC;
            ret_pd_n = 1'b0;
            dly_load = 1'b1;
            dly_val  = trfc_load(trfc_cfg);
          end
        end else if (user_cmd == UC_PDN) begin
          st_n = M_PD;
        end else if (user_cmd == UC_SRF) begin
          st_n = M_SRQ;
        end
      end
      M_PD: begin
        if (due) begin
          st_n     = M_PWAKE;
          dly_load = 1'b1;
          dly_val  = DLY_W'(WAKE_CYC - 1);
        end else if (user_cmd == UC_PDN) begin
          st_n = M_NORM;
        end
      end
      M_PWAKE: begin
        if (dly_done && eng_grant) begin
          fire     = 1'b1;
          st_n     = M_TRFC;
          ret_pd_n = 1'b1;
          dly_load = 1'b1;
          dly_val  = trfc_load(trfc_cfg);
        end
      end
      M_TRFC: begin
        if (dly_done) st_n = ret_pd_q ? M_PD : M_NORM;
      end
      M_SRQ: begin
        if (eng_grant) begin
          fire = 1'b1;
          st_n = M_SR;
        end
      end
      M_SR: begin
        if (user_cmd == UC_SRF) begin
          st_n     = M_SRX;
          dly_load = 1'b1;
          dly_val  = DLY_W'(SRX_CYC - 1);
        end
      end
      M_SRX: begin
        if (dly_done) st_n = M_NORM;
      end
      default: st_n = M_NORM;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= M_NORM;
      ret_pd_q  <= 1'b0;
      issue_ref <= 1'b0;
    end else begin
      mode_q    <= st_n;
      ret_pd_q  <= ret_pd_n;
      issue_ref <= fire;
    end
  end

  assign timer_hold = (mode_q == M_SR);
  assign cke        = cke_for(mode_q);
  assign busy       = busy_for(mode_q, due);
  assign ref_req    = (mode_q == M_NORM && due) || mode_q == M_PWAKE || mode_q == M_SRQ;
  assign fwd_vld    = (mode_q == M_NORM) && !due && cmd_passes(user_cmd);
  assign fwd_cmd    = fwd_vld ? user_cmd : UC_NOP;

endmodule

// File: rtl/refresh_power_mgr.sv
module refresh_power_mgr
  import rpm_pkg::*;
#(
  parameter int REFI_W   = 16,
  parameter int TRFC_W   = 4,
  parameter int REFI_RST = 2228,
  parameter int WAKE_CYC = 1,
  parameter int SRX_CYC  = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        user_cmd,
  input  logic [REFI_W-1:0] refi_cfg,
  input  logic [TRFC_W-1:0] trfc_cfg,
  input  logic              eng_grant,
  output logic              ref_req,
  output logic              issue_ref,
  output logic              cke,
  output logic              busy,
  output logic              fwd_vld,
  output logic [2:0]        fwd_cmd
);

  localparam int SRX_W   = $clog2(SRX_CYC + 1);
  localparam int WAKE_W  = $clog2(WAKE_CYC + 1);
  localparam int DLY_A   = (SRX_W > TRFC_W) ? SRX_W : TRFC_W;
  localparam int DLY_W   = (DLY_A > WAKE_W) ? DLY_A : WAKE_W;

  // named internal events, also observed by the checker
  mode_e             mode_q;
  logic [REFI_W-1:0] rfsh_cnt;
  logic              rfsh_due;
  logic              rfsh_fire;
  logic              rfsh_hold;
  logic              dly_load;
  logic [DLY_W-1:0]  dly_val;
  logic              dly_done;

  rpm_refresh_timer #(.REFI_W(REFI_W), .REFI_RST(REFI_RST)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload (rfsh_fire),
    .hold   (rfsh_hold),
    .refi   (refi_cfg),
    .cnt    (rfsh_cnt),
    .due    (rfsh_due)
  );

  rpm_delay_timer #(.W(DLY_W)) u_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (dly_load),
    .val   (dly_val),
    .done  (dly_done)
  );

  rpm_mode_fsm #(
    .TRFC_W(TRFC_W), .DLY_W(DLY_W), .WAKE_CYC(WAKE_CYC), .SRX_CYC(SRX_CYC)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .user_cmd   (user_cmd),
    .trfc_cfg   (trfc_cfg),
    .eng_grant  (eng_grant),
    .due        (rfsh_due),
    .dly_done   (dly_done),
    .mode_q     (mode_q),
    .dly_load   (dly_load),
    .dly_val    (dly_val),
    .fire       (rfsh_fire),
    .timer_hold (rfsh_hold),
    .issue_ref  (issue_ref),
    .ref_req    (ref_req),
    .cke        (cke),
    .busy       (busy),
    .fwd_vld    (fwd_vld),
    .fwd_cmd    (fwd_cmd)
  );

endmodule

// File: rtl/rpm_chk.sv
module rpm_chk
  import rpm_pkg::*;
#(
  parameter int REFI_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        user_cmd,
  input logic [REFI_W-1:0] refi_cfg,
  input logic              eng_grant,
  input mode_e             mode,
  input logic [REFI_W-1:0] rcnt,
  input logic              issue_ref,
  input logic              cke,
  input logic              busy,
  input logic              fwd_vld
);

  a_r3_grant_before_issue: assert property (@(posedge clk) disable iff (!rst_n)
    issue_ref |-> $past(eng_grant));

  a_r2_reload_on_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_ref && $past(refi_cfg) != '0) |-> rcnt == ($past(refi_cfg) - REFI_W'(1)));

  a_r5_no_pass_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !fwd_vld);

  a_r7_pd_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_NORM && !busy && user_cmd == UC_PDN) |=> !cke);

  a_r9_sr_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SR && $past(mode) == M_SRQ) |-> (issue_ref && !cke));

  a_r10_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SR) |=> $stable(rcnt));

  a_r8_wake_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_ref && $past(mode) == M_PWAKE) |-> cke);

  a_r11_exit_drops_cmds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SRX) |-> !fwd_vld);

endmodule

bind refresh_power_mgr rpm_chk #(.REFI_W(REFI_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .user_cmd  (user_cmd),
  .refi_cfg  (refi_cfg),
  .eng_grant (eng_grant),
  .mode      (mode_q),
  .rcnt      (rfsh_cnt),
  .issue_ref (issue_ref),
  .cke       (cke),
  .busy      (busy),
  .fwd_vld   (fwd_vld)
);

// File: tb/sim_refresh_power_mgr.sv
module sim_refresh_power_mgr;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 20000;
  localparam int LIM        = 5000;
  localparam int WAKE       = 1;
  localparam int SRX        = 200;

  // {expected forward, command code} for normal-mode pass-through (R6)
  localparam logic [3:0] VEC [0:5] = '{4'b0000, 4'b1001, 4'b1010, 4'b1011, 4'b1100, 4'b1111};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  user_cmd = 3'b000;
  logic [15:0] refi_cfg = 16'd2228;
  logic [3:0]  trfc_cfg = 4'd9;
  logic        eng_grant = 1'b1;
  logic        ref_req, issue_ref, cke, busy, fwd_vld;
  logic [2:0]  fwd_cmd;

  int nvec = 0;
  int nfail = 0;
  int cyc = 0;

  refresh_power_mgr u0 (
    .clk(clk), .rst_n(rst_n), .user_cmd(user_cmd), .refi_cfg(refi_cfg),
    .trfc_cfg(trfc_cfg), .eng_grant(eng_grant), .ref_req(ref_req),
    .issue_ref(issue_ref), .cke(cke), .busy(busy), .fwd_vld(fwd_vld),
    .fwd_cmd(fwd_cmd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      nvec++; nfail++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WDOG);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  task automatic chk(input string rq, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic adv;
    @(negedge clk); #1;
  endtask

  task automatic wait_issue(output int n);
    n = 0;
    while (!issue_ref && n < LIM) begin adv; n++; end
  endtask

  initial begin
    int n;
    int bad;
    repeat (3) adv;
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 cke", int'(cke), 1);
    chk("R1 busy", int'(busy), 0);
    chk("R1 ref_req", int'(ref_req), 0);
    chk("R1 issue_ref", int'(issue_ref), 0);
    refi_cfg = 16'd200;

    // R6 pass-through table
    for (int i = 0; i < 6; i++) begin
      user_cmd = VEC[i][2:0];
      #1;
      chk("R6 fwd_vld", int'(fwd_vld), int'(VEC[i][3]));
      chk("R6 fwd_cmd", int'(fwd_cmd), VEC[i][3] ? int'(VEC[i][2:0]) : 0);
      adv;
    end
    user_cmd = 3'b000;

    // R7 power-down toggle
    user_cmd = 3'b101; adv;
    user_cmd = 3'b001; #1;
    chk("R7 pd cke low", int'(cke), 0);
    chk("R7 pd drops cmd", int'(fwd_vld), 0);
    adv;
    user_cmd = 3'b101; adv;
    user_cmd = 3'b000;
    chk("R7 pd exit cke", int'(cke), 1);
    adv;

    // first refresh from reset load, then R4 recovery with trfc=9
    wait_issue(n);
    chk("R4 busy in strobe", int'(busy), 1);
    repeat (8) adv;
    chk("R4 busy last trfc", int'(busy), 1);
    adv;
    chk("R4 busy after trfc", int'(busy), 0);
    // R2 spacing: 9 cycles already advanced
    wait_issue(n);
    chk("R2 refresh spacing", n + 9, 200);

    // R2 request timing, R3 grant gating, R5 priority
    eng_grant = 1'b0;
    n = 0;
    adv; n++;
    while (!ref_req && n < LIM) begin adv; n++; end
    chk("R2 req after reload", n, 199);
    user_cmd = 3'b001; #1;
    chk("R5 busy when due", int'(busy), 1);
    chk("R5 read blocked", int'(fwd_vld), 0);
    bad = 0;
    repeat (3) begin adv; if (issue_ref) bad++; end
    chk("R3 no strobe without grant", bad, 0);
    chk("R3 req held", int'(ref_req), 1);
    user_cmd = 3'b000; trfc_cfg = 4'd0; eng_grant = 1'b1;
    adv;
    chk("R3 strobe after grant", int'(issue_ref), 1);
    chk("R4 busy trfc zero", int'(busy), 1);
    adv;
    chk("R4 trfc zero acts as one", int'(busy), 0);
    refi_cfg = 16'd60; trfc_cfg = 4'd5;

    // R8 refresh inside power-down
    user_cmd = 3'b101; adv;
    user_cmd = 3'b000;
    n = 0;
    while (!cke && n < LIM) begin adv; n++; end
    chk("R8 wake cke high", int'(cke), 1);
    repeat (WAKE) adv;
    chk("R8 strobe after wake", int'(issue_ref), 1);
    chk("R8 cke high at strobe", int'(cke), 1);
    n = 0;
    adv; n++;
    while (cke && n < LIM) begin adv; n++; end
    chk("R8 back asleep after trfc", n, 5);
    user_cmd = 3'b010; #1;
    chk("R8 still in power-down", int'(fwd_vld), 0);
    adv;
    user_cmd = 3'b101; adv;
    user_cmd = 3'b000;
    chk("R7 second toggle exits", int'(cke), 1);
    refi_cfg = 16'd300;

    // R9..R11 self-refresh
    wait_issue(n);
    while (busy) adv;
    user_cmd = 3'b110; eng_grant = 1'b0; adv;
    user_cmd = 3'b000;
    chk("R9 req for entry", int'(ref_req), 1);
    chk("R9 no strobe yet", int'(issue_ref), 0);
    eng_grant = 1'b1; adv;
    chk("R9 entry strobe", int'(issue_ref), 1);
    chk("R9 cke low with strobe", int'(cke), 0);
    adv;
    bad = 0;
    for (int k = 0; k < 400; k++) begin
      user_cmd = (k % 2 == 0) ? 3'b001 : 3'b101; #1;
      if (fwd_vld || issue_ref || cke || ref_req) bad++;
      adv;
    end
    chk("R10 self-refresh quiet", bad, 0);
    user_cmd = 3'b110; adv;
    user_cmd = 3'b000;
    chk("R10 exit raises cke", int'(cke), 1);
    chk("R11 busy at exit", int'(busy), 1);
    repeat (SRX - 1) adv;
    chk("R11 busy end of window", int'(busy), 1);
    adv;
    chk("R11 busy released", int'(busy), 0);
    wait_issue(n);
    chk("R10 counter frozen in self-refresh", n + SRX, 300);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule